// File: doc/BRIEF.md
# Serial flash program/erase sequencer

This block carries out a whole write or erase job on a serial NOR flash over a single-line SPI link (mode 0: clock idles low, data launched on the falling edge and sampled on the rising edge, most significant bit first). The host pulses `start` with a job code, a 24-bit address and, for a program, a byte count. The block first sends write-enable. It then reads the status register to confirm that the write-enable latch is set, and sends the program or erase command. After that it reads status again and again until the device reports it is no longer busy. It ends the job with a one-cycle `done` pulse, with `err` raised in the same cycle if the job failed.

Page data is taken from a byte stream. `wr_req` pulses once for each byte, and the block latches `wr_data` on the clock edge that ends that pulse. Jobs that cannot be carried out are refused before anything reaches the bus. These are a program that is empty, larger than a page or that runs past a page boundary, an erase type configured with size zero, a disabled chip erase, and an unknown job code. Both status flags can sit at any bit position. Chip select stays high for a configurable number of SCK periods between frames.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, and `done`, `err`, `busy` and `wr_req` are 0.
- R2: Every accepted job first sends a one-byte frame 0x06, then a two-byte status frame starting with 0x05, before the job's command frame.
- R3: If bit WEL_BIT of the status byte read after write-enable is 0, the job ends with `err` = 1 and no command frame is sent.
- R4: Job code 0 (program) sends 0x02, then three address bytes most significant first, then `len` bytes taken from `wr_data` in stream order. `wr_req` pulses once per byte and only while `cs_n` is low.
- R5: A program with `len` = 0, `len` > PAGE_BYTES, or (`addr` mod PAGE_BYTES) + `len` > PAGE_BYTES ends with `done` and `err` one cycle after `start`, and no frame is sent.
- R6: Job codes 1, 2 and 3 send opcodes 0x20 (sector), 0x52 (32 KiB block) and 0xD8 (64 KiB block), each followed by three address bytes. Job code 4 sends 0xC7 alone.
- R7: Job codes 1 to 3 whose size parameter is 0, job code 4 with CHIP_EN = 0, and job codes 5 to 7 are refused with `err` and no frame.
- R8: After the command frame, status frames repeat until bit WIP_BIT of the status byte reads 0. The job then ends with `done` and `err` = 0.
- R9: If POLL_MAX status polls in a row all read busy, the job ends with `err` = 1 after exactly POLL_MAX polls.
- R10: Between frames `cs_n` stays high for at least 2*CS_GAP clock cycles (CS_GAP SCK periods), and `sck` is low whenever `cs_n` is high.
- R11: `start` is ignored while `busy` is 1. `done` lasts one cycle, and `err` is never 1 without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one SCK period takes two cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job request, sampled while idle |
| cmd | input | 3 | Job code: 0 program, 1 sector, 2 32 KiB, 3 64 KiB, 4 chip erase |
| addr | input | 24 | Flash byte address |
| len | input | $clog2(PAGE_BYTES+1) | Program byte count |
| wr_data | input | 8 | Page data byte, latched at the edge ending a `wr_req` cycle |
| wr_req | output | 1 | Data byte taken |
| done | output | 1 | One-cycle job completion pulse |
| err | output | 1 | Job failed, valid with `done` |
| busy | output | 1 | Job in progress |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
The bound checker watches the cycle-level rules on every cycle: the one-cycle `done`, `err` only with `done`, a quiet bus while idle, `sck` low with chip select high, the minimum chip-select high time, and `wr_req` only inside a frame. The content of each job can only be shown by the bench's scenarios against its flash model. That covers the order of frames, opcodes, address bytes and page data, the write-enable check, the number of polls before success or timeout, the refusal of illegal jobs, and a start request that arrives during a job.

// File: rtl/flash_pe_seq.sv
module flash_pe_seq #(
  parameter int PAGE_BYTES = 256,
  parameter int WIP_BIT    = 0,
  parameter int WEL_BIT    = 1,
  parameter int CS_GAP     = 1,
  parameter int POLL_MAX   = 1024,
  parameter int SECT_SIZE  = 4096,
  parameter int BLK32_SIZE = 32768,
  parameter int BLK64_SIZE = 65536,
  parameter bit CHIP_EN    = 1'b1,
  localparam int LW = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cmd,
  input  logic [23:0]   addr,
  input  logic [LW-1:0] len,
  input  logic [7:0]    wr_data,
  output logic          wr_req,
  output logic          done,
  output logic          err,
  output logic          busy,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int GW = $clog2(2 * CS_GAP + 1);
  localparam int CW = $clog2(POLL_MAX + 1);
  localparam logic [LW:0] PAGE_L = (LW+1)'(PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;
  typedef enum logic [1:0] {P_WREN, P_WEL, P_CMD, P_POLL} step_t;

  st_t           st;
  step_t         step;
  logic          ph;
  logic [2:0]    bitc;
  logic [7:0]    sh;
  logic [23:0]   hdr, caddr;
  logic [1:0]    hleft;
  logic [LW-1:0] dleft, clen;
  logic [2:0]    ccmd;
  logic          wel_f, wip_f;
  logic [GW-1:0] gcnt;
  logic [CW-1:0] pcnt;
  logic [LW:0]   span;
  logic          bad;

  function automatic logic [7:0] op_of(input logic [2:0] c);
    case (c)
      3'd0:    return 8'h02;
      3'd1:    return 8'h20;
      3'd2:    return 8'h52;
      3'd3:    return 8'hD8;
      default: return 8'hC7;
    endcase
  endfunction

  assign span = (LW+1)'(addr[PW-1:0]) + {1'b0, len};

  always_comb
    case (cmd)
      3'd0:    bad = (len == '0) || (span > PAGE_L);
      3'd1:    bad = (SECT_SIZE == 0);
      3'd2:    bad = (BLK32_SIZE == 0);
      3'd3:    bad = (BLK64_SIZE == 0);
      3'd4:    bad = !CHIP_EN;
      default: bad = 1'b1;
    endcase

  assign busy   = (st != S_IDLE);
  assign cs_n   = (st != S_XFER);
  assign sck    = (st == S_XFER) && ph;
  assign mosi   = (st == S_XFER) && sh[7];
  assign wr_req = (st == S_XFER) && ph && (bitc == 3'd7) && (hleft == 2'd0) && (dleft != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= P_WREN; ph <= 1'b0; bitc <= '0; sh <= '0;
      hdr <= '0; caddr <= '0; hleft <= '0; dleft <= '0; clen <= '0; ccmd <= '0;
      wel_f <= 1'b0; wip_f <= 1'b0; gcnt <= '0; pcnt <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (bad) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              ccmd <= cmd; caddr <= addr; clen <= len;
              st <= S_XFER; step <= P_WREN; ph <= 1'b0; bitc <= '0;
              sh <= 8'h06; hleft <= 2'd0; dleft <= '0;
            end
          end
        S_XFER:
          if (!ph) ph <= 1'b1;
          else begin
            ph <= 1'b0;
            if (bitc == 3'(7 - WEL_BIT)) wel_f <= miso;
            if (bitc == 3'(7 - WIP_BIT)) wip_f <= miso;
            if (bitc != 3'd7) begin
              bitc <= bitc + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end else begin
              bitc <= '0;
              if (hleft != 2'd0) begin
                sh    <= hdr[23:16];
                hdr   <= {hdr[15:0], 8'h00};
                hleft <= hleft - 2'd1;
              end else if (dleft != '0) begin
                sh    <= wr_data;
                dleft <= dleft - 1'b1;
              end else begin
                st   <= S_GAP;
                gcnt <= GW'(2 * CS_GAP - 1);
              end
            end
          end
        default:
          if (gcnt != '0) gcnt <= gcnt - 1'b1;
          else begin
            st <= S_XFER; ph <= 1'b0; bitc <= '0;
            sh <= 8'h05; hdr <= '0; hleft <= 2'd1; dleft <= '0;
            case (step)
              P_WREN: step <= P_WEL;
              P_WEL:
                if (!wel_f) begin
                  st <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else begin
                  step  <= P_CMD;
                  sh    <= op_of(ccmd);
                  hdr   <= caddr;
                  hleft <= (ccmd == 3'd4) ? 2'd0 : 2'd3;
                  dleft <= (ccmd == 3'd0) ? clen : '0;
                end
              P_CMD: begin
                step <= P_POLL;
                pcnt <= CW'(1);
              end
              default:
                if (!wip_f) begin
                  st <= S_IDLE; done <= 1'b1;
                end else if (pcnt == CW'(POLL_MAX)) begin
                  st <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else pcnt <= pcnt + 1'b1;
            endcase
          end
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
  parameter int CS_GAP = 1
) (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic err,
  input logic busy,
  input logic sck,
  input logic cs_n,
  input logic wr_req
);
  localparam int GW = $clog2(2 * CS_GAP + 2);
  localparam logic [GW-1:0] GMIN = GW'(2 * CS_GAP);
  logic [GW-1:0] hi_run;

  always_ff @(posedge clk)
    if (!rst_n) hi_run <= GMIN;
    else if (!cs_n) hi_run <= '0;
    else if (hi_run < GMIN) hi_run <= hi_run + 1'b1;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_err_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
  assert_sck_parked_R10: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> hi_run >= GMIN);
  assert_req_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n) wr_req |-> (!cs_n && busy));
endmodule

bind flash_pe_seq flash_pe_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .busy(busy),
  .sck(sck), .cs_n(cs_n), .wr_req(wr_req)
);

// File: tb/sim_flash_pe_seq.sv
module sim_flash_pe_seq;
  localparam int PER = 10;
  localparam int PAGE = 256;
  localparam int GAP = 2;
  localparam int PMAX = 6;
  localparam int LW = $clog2(PAGE + 1);

  logic clk = 0, rst_n = 0, start = 0, miso = 0;
  logic [2:0] cmd = 0;
  logic [23:0] addr = 0;
  logic [LW-1:0] len = 0;
  logic [7:0] wr_data;
  logic wr_req, done, err, busy, sck, cs_n, mosi;
  int vec = 0, bad = 0;

  always #(PER/2) clk = ~clk;

  flash_pe_seq #(.PAGE_BYTES(PAGE), .WIP_BIT(0), .WEL_BIT(1), .CS_GAP(GAP), .POLL_MAX(PMAX),
                 .SECT_SIZE(4096), .BLK32_SIZE(0), .BLK64_SIZE(65536), .CHIP_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .len(len),
    .wr_data(wr_data), .wr_req(wr_req), .done(done), .err(err), .busy(busy),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  logic [7:0] pg [0:299];
  int widx = 0, nreq = 0;
  bit pend = 0;
  assign wr_data = pg[widx];
  always @(negedge clk) begin
    if (pend) begin widx++; nreq++; end
    pend = wr_req;
  end

  int run = 0, mingap = 1000;
  always @(negedge clk)
    if (cs_n) run++;
    else begin
      if (run > 0 && run < mingap) mingap = run;
      run = 0;
    end

  int bitn = 0, nfr = 0, cbn = 0, busy_left = 0, cfg_busy = 0;
  bit wel = 0, cfg_wel = 1;
  logic [7:0] cur = 0, stat_l = 0;
  logic [7:0] fb [0:299];
  logic [7:0] cb [0:299];
  logic [7:0] ops [0:63];

  always @(negedge cs_n) bitn = 0;
  always @(posedge sck) if (!cs_n) begin
    cur = {cur[6:0], mosi};
    bitn++;
    if (bitn % 8 == 0 && bitn / 8 <= 300) fb[bitn/8-1] = cur;
    if (bitn == 8) begin
      stat_l = 8'h00;
      stat_l[0] = (busy_left > 0);
      stat_l[1] = wel;
    end
  end
  always @(negedge sck)
    if (!cs_n && fb[0] == 8'h05 && bitn >= 8 && bitn < 16) miso = stat_l[15-bitn];
  always @(posedge cs_n) if (bitn >= 8) begin
    if (nfr < 64) ops[nfr] = fb[0];
    nfr++;
    if (fb[0] == 8'h06) wel = cfg_wel;
    else if (fb[0] == 8'h05) begin
      if (busy_left > 0) busy_left--;
    end else begin
      cbn = bitn / 8;
      for (int i = 0; i < cbn && i < 300; i++) cb[i] = fb[i];
      wel = 0;
      busy_left = cfg_busy;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit rejected(input int c, input int a, input int l);
    case (c)
      0: return (l == 0) || (l > PAGE) || ((a % PAGE) + l > PAGE);
      1, 3, 4: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] opc(input int c);
    case (c)
      0: return 8'h02;
      1: return 8'h20;
      2: return 8'h52;
      3: return 8'hD8;
      default: return 8'hC7;
    endcase
  endfunction

  task automatic job(input int c, input int a, input int l, input int bz, input bit wok);
    int n, polls, efr;
    bit rej, eerr, ferr, ok;
    for (int i = 0; i < 300; i++) pg[i] = 8'($urandom);
    widx = 0; nreq = 0; nfr = 0; cbn = 0;
    cfg_busy = bz; cfg_wel = wok;
    rej = rejected(c, a, l);
    @(negedge clk);
    start = 1; cmd = 3'(c); addr = 24'(a); len = LW'(l);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      start = 0;
      if (done || n > 20000) break;
      if (n == 10 && busy) begin start = 1; cmd = 3'd4; end
    end
    start = 0;
    ferr = err;
    chk(n <= 20000, "R11 job finished", n, 0);
    if (rej) begin
      eerr = 1; efr = 0;
      chk(n == 1, "R5/R7 refusal latency", n, 1);
    end else if (!wok) begin
      eerr = 1; efr = 2;
    end else begin
      polls = (bz + 1 > PMAX) ? PMAX : bz + 1;
      eerr = (bz + 1 > PMAX);
      efr = 3 + polls;
    end
    chk(ferr == eerr, c == 0 ? "R5/R8/R9 err on program" : "R7/R8/R9 err on erase", ferr, eerr);
    chk(nfr == efr, "R2/R3/R8/R9 frame count", nfr, efr);
    if (!rej && nfr == efr) begin
      ok = (ops[0] == 8'h06) && (ops[1] == 8'h05);
      if (wok) begin
        ok = ok && (ops[2] == opc(c));
        for (int i = 3; i < efr; i++) ok = ok && (ops[i] == 8'h05);
      end
      chk(ok, "R2/R6 frame order", ops[2], opc(c));
    end
    if (!rej && wok) begin
      if (c == 4) chk(cbn == 1, "R6 chip erase without address", cbn, 1);
      else begin
        chk(cbn == 4 + (c == 0 ? l : 0), "R4/R6 command length", cbn, 4 + (c == 0 ? l : 0));
        chk({cb[1], cb[2], cb[3]} == 24'(a), "R4/R6 address bytes", {cb[1], cb[2], cb[3]}, a);
      end
      if (c == 0) begin
        ok = 1;
        for (int i = 0; i < l; i++) ok = ok && (cb[4+i] == pg[i]);
        chk(ok, "R4 page data order", ok, 1);
        @(negedge clk);
        chk(nreq == l, "R4 one wr_req per byte", nreq, l);
      end
    end
    if (!wok && !rej) chk(cbn == 0, "R3 no command after missing WEL", cbn, 0);
    @(negedge clk);
    chk(!done && !err, "R11 done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    bad++;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !sck && !done && !err && !busy && !wr_req, "R1 reset state",
        {cs_n, sck, done, err, busy, wr_req}, 6'b100000);
    job(0, 24'h001200, 256, 2, 1);
    job(0, 24'h003410, 240, 0, 1);
    job(0, 24'h003410, 241, 0, 1);
    job(0, 24'h000000, 0, 0, 1);
    job(0, 24'h000000, 257, 0, 1);
    job(0, 24'h0000FF, 1, 1, 1);
    job(1, 24'h045000, 0, 3, 1);
    job(2, 24'h010000, 0, 0, 1);
    job(3, 24'h7F0000, 0, 1, 1);
    job(4, 24'h000000, 0, 4, 1);
    job(5, 0, 0, 0, 1);
    job(7, 0, 0, 0, 1);
    job(1, 24'h001000, 0, 0, 0);
    job(3, 24'h020000, 0, 5, 1);
    job(3, 24'h020000, 0, 6, 1);
    job(0, 24'h000020, 8, 9, 1);
    for (int k = 0; k < 30; k++) begin
      int c, a, l;
      c = ($urandom % 4 == 0) ? 0 : int'($urandom % 8);
      a = int'($urandom & 32'hFFFFFF);
      l = int'($urandom % 40);
      if ($urandom % 4 == 0) a = a & 32'hFFFF00;
      job(c, a, l, int'($urandom % 8), ($urandom % 8) != 0);
    end
    chk(mingap >= 2 * GAP, "R10 chip select high time", mingap, 2 * GAP);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule